// File: doc/BRIEF.md
# Endian-Selectable Aligned Memory Port

This block is a load/store port sitting in front of a small byte-addressed data store built from 32-bit words. Each request carries a byte address, a size code (byte, halfword or word), a runtime endianness select, a signed/unsigned flag for loads and write data that is right-justified in the 32-bit input. On a store the port moves the value into the right byte lanes of the addressed word and drives matching byte enables. On a load it picks the addressed bytes back out of the word and zero- or sign-extends them to 32 bits.

Only aligned accesses are served, so every access touches exactly one word. When the start address is not a multiple of the access size, the port raises an error pulse and leaves the memory untouched. A load that fails this way returns zero. Load data arrives one clock after the request and comes with a valid pulse.

Top module: `endian_mem_port`

## Requirements
- R1: With big_end_i=0, a word 0x12345678 stored at word address p reads back as bytes 0x78, 0x56, 0x34, 0x12 at addresses p, p+1, p+2, p+3. Halfword loads at p and p+2 return 0x5678 and 0x1234.
- R2: With big_end_i=1, the same stored word reads back as bytes 0x12, 0x34, 0x56, 0x78 at p..p+3. Halfword loads at p and p+2 return 0x1234 and 0x5678.
- R3: Physical lane i is bits 8i+7..8i of a memory word, and be_o bit i enables lane i. A byte at offset o = addr_i[1:0] uses lane o when little-endian and lane 3-o when big-endian. A word store enables all four lanes (be_o=4'b1111).
- R4: A halfword store enables two adjacent lanes. Little-endian: offset 0 gives 4'b0011 and offset 2 gives 4'b1100. Big-endian: offset 0 gives 4'b1100 and offset 2 gives 4'b0011.
- R5: Size codes are 0 = byte, 1 = halfword, 2 = word and 3 = illegal. A byte is always aligned. A halfword needs addr_i[0]=0. A word needs addr_i[1:0]=0. Code 3 is always treated as misaligned.
- R6: A misaligned request drives err_o high for exactly the clock after the request, keeps be_o at zero and leaves the memory contents unchanged.
- R7: A misaligned load still pulses rvalid_o, with rdata_o = 0 in that cycle.
- R8: With signed_i=0, a load fills bits above the access size with zeros (byte 0xEA gives 0x000000EA).
- R9: With signed_i=1, a load copies the top bit of the loaded value upward (byte 0xEA gives 0xFFFFFFEA, halfword 0x8001 gives 0xFFFF8001).
- R10: rvalid_o is high for exactly the one cycle after each load request and low otherwise. rdata_o keeps the last load result across stores and idle cycles.
- R11: While rst_ni is low, rvalid_o, err_o and rdata_o are zero and every memory word is cleared.
- R12: be_o is zero for loads and when req_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one access per cycle |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | ADDR_W | Byte address |
| size_i | input | 2 | Access size code |
| big_end_i | input | 1 | 1 = big-endian lane order |
| signed_i | input | 1 | 1 = sign-extend load data |
| wdata_i | input | 32 | Store value, right-justified |
| be_o | output | 4 | Byte enables of the current store |
| rvalid_o | output | 1 | Load data valid, one cycle after request |
| rdata_o | output | 32 | Extended load data |
| err_o | output | 1 | Misalignment error pulse |

## Verification
The hardest case to expose from the ports is a misaligned store that wrongly writes part of the memory. Its only visible sign is a later load that returns a changed word. For this reason the stimulus stores a known word first, then issues misaligned halfword, word and illegal-size stores to that word, then reads it back with an aligned word load. Endianness mixing is covered in a similar way. Words are written in one mode and read as bytes and halfwords in the other, and the single-byte stores in each mode are combined into one word whose lane pattern is then checked.

// File: rtl/emp_pkg.sv
package emp_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = LANE_W * LANES;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;
endpackage

// File: rtl/emp_lane_map.sv
module emp_lane_map
  import emp_pkg::*;
(
  input  logic [OFF_W-1:0]  off_i,
  input  size_e             size_i,
  input  logic              big_end_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              aligned_o,
  output logic [OFF_W-1:0]  lane_o,
  output logic [LANES-1:0]  mask_o,
  output logic [WORD_W-1:0] wlanes_o
);
  logic [LANES-1:0] base_mask;

  always_comb begin
    aligned_o = 1'b0;
    lane_o    = off_i;
    base_mask = '0;
    unique case (size_i)
      SZ_BYTE: begin
        aligned_o = 1'b1;
        base_mask = 4'b0001;
        lane_o    = big_end_i ? (2'd3 - off_i) : off_i;
      end
      SZ_HALF: begin
        aligned_o = ~off_i[0];
        base_mask = 4'b0011;
        lane_o    = big_end_i ? (2'd2 - off_i) : off_i;
      end
      SZ_WORD: begin
        aligned_o = (off_i == '0);
        base_mask = 4'b1111;
        lane_o    = '0;
      end
      default: begin
        aligned_o = 1'b0;
        base_mask = '0;
        lane_o    = '0;
      end
    endcase
    mask_o   = base_mask << lane_o;
    wlanes_o = wdata_i << {lane_o, 3'b000};
  end
endmodule

// File: rtl/emp_mem.sv
module emp_mem
  import emp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [DEPTH-1:0][WORD_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < LANES; i++) begin
        if (be_i[i]) mem_q[idx_i][i*LANE_W +: LANE_W] <= wdata_i[i*LANE_W +: LANE_W];
      end
    end
  end

  assign rdata_o = mem_q[idx_i];

  // R6
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mem_q));
endmodule

// File: rtl/emp_load_ext.sv
module emp_load_ext
  import emp_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [OFF_W-1:0]  lane_i,
  input  size_e             size_i,
  input  logic              signed_i,
  output logic [WORD_W-1:0] data_o
);
  logic [WORD_W-1:0] shifted;

  always_comb begin
    shifted = word_i >> {lane_i, 3'b000};
    unique case (size_i)
      SZ_BYTE: data_o = {{(WORD_W-8){signed_i & shifted[7]}}, shifted[7:0]};
      SZ_HALF: data_o = {{(WORD_W-16){signed_i & shifted[15]}}, shifted[15:0]};
      SZ_WORD: data_o = shifted;
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/endian_mem_port.sv
module endian_mem_port
  import emp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              big_end_i,
  input  logic              signed_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [LANES-1:0]  be_o,
  output logic              rvalid_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              err_o
);
  size_e             size;
  logic              aligned;
  logic [OFF_W-1:0]  lane;
  logic [LANES-1:0]  mask;
  logic [WORD_W-1:0] wlanes;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] ld_data;
  logic              wr_en;
  logic              rd_req;
  size_e             rsize_q;
  logic              rsign_q;

  assign size = size_e'(size_i);

  emp_lane_map u_map (
    .off_i     (addr_i[OFF_W-1:0]),
    .size_i    (size),
    .big_end_i (big_end_i),
    .wdata_i   (wdata_i),
    .aligned_o (aligned),
    .lane_o    (lane),
    .mask_o    (mask),
    .wlanes_o  (wlanes)
  );

  assign wr_en  = req_i & we_i & aligned;
  assign rd_req = req_i & ~we_i;
  assign be_o   = wr_en ? mask : '0;

  emp_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .idx_i   (addr_i[ADDR_W-1:OFF_W]),
    .be_i    (be_o),
    .wdata_i (wlanes),
    .rdata_o (rd_word)
  );

  emp_load_ext u_ext (
    .word_i   (rd_word),
    .lane_i   (lane),
    .size_i   (size),
    .signed_i (signed_i),
    .data_o   (ld_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      err_o    <= 1'b0;
      rdata_o  <= '0;
      rsize_q  <= SZ_BYTE;
      rsign_q  <= 1'b0;
    end else begin
      rvalid_o <= rd_req;
      err_o    <= req_i & ~aligned;
      if (rd_req) begin
        rdata_o <= aligned ? ld_data : '0;
        rsize_q <= size;
        rsign_q <= signed_i;
      end
    end
  end

  // R6
  misalign_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !aligned) |=> err_o);
  // R6
  err_no_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !aligned) |-> (be_o == '0));
  // R7
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && rvalid_o) |-> (rdata_o == '0));
  // R10
  rvalid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
  // R4
  half_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && size == SZ_HALF) |-> ($countones(be_o) == 2 && (be_o == 4'b0011 || be_o == 4'b1100)));
  // R8
  zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !err_o && rsize_q == SZ_BYTE && !rsign_q) |-> (rdata_o[WORD_W-1:8] == '0));
endmodule

// File: tb/sim_endian_mem_port.sv
module sim_endian_mem_port;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 36;

  // fields: tag[83:80] we[79] addr[78:73] size[72:71] big[70] sgn[69] wdata[68:37] be[36:33] err[32] rdata[31:0]
  localparam logic [83:0] VEC [0:NV-1] = '{
    {4'd3,  1'b1, 6'd0,  2'd2, 1'b0, 1'b0, 32'h12345678, 4'hF, 1'b0, 32'h0},        // R3 word store LE
    {4'd1,  1'b0, 6'd0,  2'd0, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 32'h00000078},        // R1
    {4'd1,  1'b0, 6'd1,  2'd0, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 32'h00000056},
    {4'd1,  1'b0, 6'd2,  2'd0, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 32'h00000034},
    {4'd1,  1'b0, 6'd3,  2'd0, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 32'h00000012},
    {4'd1,  1'b0, 6'd0,  2'd1, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 32'h00005678},
    {4'd1,  1'b0, 6'd2,  2'd1, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 32'h00001234},
    {4'd2,  1'b0, 6'd0,  2'd0, 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 32'h00000012},        // R2
    {4'd2,  1'b0, 6'd1,  2'd0, 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 32'h00000034},
    {4'd2,  1'b0, 6'd2,  2'd0, 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 32'h00000056},
    {4'd2,  1'b0, 6'd3,  2'd0, 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 32'h00000078},
    {4'd2,  1'b0, 6'd0,  2'd1, 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 32'h00001234},
    {4'd2,  1'b0, 6'd2,  2'd1, 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 32'h00005678},
    {4'd3,  1'b1, 6'd4,  2'd2, 1'b1, 1'b0, 32'hAABBCCDD, 4'hF, 1'b0, 32'h0},        // R3 word store BE
    {4'd2,  1'b0, 6'd4,  2'd0, 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 32'h000000AA},
    {4'd1,  1'b0, 6'd4,  2'd0, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 32'h000000DD},
    {4'd3,  1'b1, 6'd9,  2'd0, 1'b0, 1'b0, 32'h000000EA, 4'h2, 1'b0, 32'h0},        // R3 LE byte lane 1
    {4'd9,  1'b0, 6'd9,  2'd0, 1'b0, 1'b1, 32'h0, 4'h0, 1'b0, 32'hFFFFFFEA},        // R9
    {4'd8,  1'b0, 6'd9,  2'd0, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 32'h000000EA},        // R8
    {4'd3,  1'b0, 6'd8,  2'd2, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 32'h0000EA00},
    {4'd3,  1'b1, 6'd9,  2'd0, 1'b1, 1'b0, 32'h00000055, 4'h4, 1'b0, 32'h0},        // R3 BE byte lane 2
    {4'd3,  1'b0, 6'd8,  2'd2, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 32'h0055EA00},
    {4'd4,  1'b1, 6'd14, 2'd1, 1'b0, 1'b0, 32'h00008001, 4'hC, 1'b0, 32'h0},        // R4 LE off 2
    {4'd9,  1'b0, 6'd14, 2'd1, 1'b0, 1'b1, 32'h0, 4'h0, 1'b0, 32'hFFFF8001},
    {4'd8,  1'b0, 6'd14, 2'd1, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 32'h00008001},
    {4'd4,  1'b1, 6'd16, 2'd1, 1'b1, 1'b0, 32'h000080AA, 4'hC, 1'b0, 32'h0},        // R4 BE off 0
    {4'd4,  1'b0, 6'd16, 2'd2, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 32'h80AA0000},
    {4'd9,  1'b0, 6'd16, 2'd1, 1'b1, 1'b1, 32'h0, 4'h0, 1'b0, 32'hFFFF80AA},
    {4'd8,  1'b0, 6'd17, 2'd0, 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 32'h000000AA},
    {4'd9,  1'b0, 6'd17, 2'd0, 1'b1, 1'b1, 32'h0, 4'h0, 1'b0, 32'hFFFFFFAA},
    {4'd4,  1'b1, 6'd22, 2'd1, 1'b1, 1'b0, 32'h00001234, 4'h3, 1'b0, 32'h0},        // R4 BE off 2
    {4'd6,  1'b1, 6'd1,  2'd1, 1'b0, 1'b0, 32'h0000FFFF, 4'h0, 1'b1, 32'h0},        // R6 misaligned half
    {4'd6,  1'b1, 6'd2,  2'd2, 1'b0, 1'b0, 32'hFFFFFFFF, 4'h0, 1'b1, 32'h0},        // R6 misaligned word
    {4'd5,  1'b1, 6'd0,  2'd3, 1'b0, 1'b0, 32'hFFFFFFFF, 4'h0, 1'b1, 32'h0},        // R5 illegal size
    {4'd6,  1'b0, 6'd0,  2'd2, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 32'h12345678},        // R6 memory unchanged
    {4'd5,  1'b0, 6'd3,  2'd0, 1'b1, 1'b0, 32'h0, 4'h0, 1'b0, 32'h00000078}         // R5 byte always aligned
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [1:0]  size_i = '0;
  logic        big_end_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  be_o;
  logic        rvalid_o;
  logic [31:0] rdata_o;
  logic        err_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  endian_mem_port u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .size_i(size_i), .big_end_i(big_end_i), .signed_i(signed_i), .wdata_i(wdata_i),
    .be_o(be_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, be_o checked before the edge, registered outputs at next negedge
  task automatic run_op(input string tag, input logic we, input logic [5:0] addr, input logic [1:0] sz,
                        input logic big, input logic sgn, input logic [31:0] wd,
                        input logic [3:0] exp_be, input logic exp_err, input logic [31:0] exp_rd);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = addr; size_i = sz;
    big_end_i = big; signed_i = sgn; wdata_i = wd;
    #1;
    check(tag, "be_o", {28'h0, be_o}, {28'h0, exp_be});
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    check(tag, "err_o", {31'h0, err_o}, {31'h0, exp_err});
    check("R10", "rvalid_o", {31'h0, rvalid_o}, {31'h0, ~we});
    if (!we) check(tag, "rdata_o", rdata_o, exp_rd);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R11 reset state
    check("R11", "rvalid_o", {31'h0, rvalid_o}, 32'h0);
    check("R11", "err_o", {31'h0, err_o}, 32'h0);
    check("R11", "rdata_o", rdata_o, 32'h0);
    rst_ni = 1'b1;
    // R12 idle gives no enables
    #1 check("R12", "be_o idle", {28'h0, be_o}, 32'h0);
    // R11 memory starts cleared
    run_op("R11", 1'b0, 6'd40, 2'd2, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [83:0] v;
      string t;
      v = VEC[i];
      t = $sformatf("R%0d", v[83:80]);
      run_op(t, v[79], v[78:73], v[72:71], v[70], v[69], v[68:37], v[36:33], v[32], v[31:0]);
    end

    // R7 misaligned loads return zero with error
    run_op("R7", 1'b0, 6'd3, 2'd1, 1'b0, 1'b0, 32'h0, 4'h0, 1'b1, 32'h0);
    run_op("R7", 1'b0, 6'd5, 2'd2, 1'b1, 1'b0, 32'h0, 4'h0, 1'b1, 32'h0);
    // R12 load with aligned address drives no enables
    run_op("R12", 1'b0, 6'd0, 2'd2, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 32'h12345678);

    // R10 rvalid is a pulse, rdata holds; R6 err is a pulse
    @(negedge clk_i);
    check("R10", "rvalid_o idle", {31'h0, rvalid_o}, 32'h0);
    check("R10", "rdata_o hold", rdata_o, 32'h12345678);
    run_op("R6", 1'b1, 6'd1, 2'd2, 1'b0, 1'b0, 32'h0, 4'h0, 1'b1, 32'h0);
    @(negedge clk_i);
    check("R6", "err_o one cycle", {31'h0, err_o}, 32'h0);
    check("R10", "rdata_o hold after store", rdata_o, 32'h12345678);

    // R11 asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R11", "rdata_o async", rdata_o, 32'h0);
    check("R11", "rvalid_o async", {31'h0, rvalid_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_op("R11", 1'b0, 6'd0, 2'd2, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 32'h0);
    run_op("R11", 1'b0, 6'd16, 2'd2, 1'b0, 1'b0, 32'h0, 4'h0, 1'b0, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule